// File: doc/BRIEF.md
# Buffered Edge-Aligned PWM Timer

This block produces one high-true, edge-aligned pulse-width-modulated output. A 16-bit up-counter advances on every input clock, with no prescaling. It counts from zero up to a period limit and then restarts, so one PWM cycle lasts limit+1 clocks. The output is high while the count is below an active compare value and low for the rest of the cycle. A compare value of zero holds the output low. Any compare value above the limit holds it high.

Software drives the block through a single write port. The port selects one of three targets: the period limit, the compare buffer or the counter. The compare value is double-buffered, and only the first compare write in each PWM cycle reaches the buffer. Later writes in the same cycle are discarded and set a sticky drop flag. Writing the counter ends the current cycle at once and opens the buffer for a new write.

A new period limit waits until the next cycle boundary. At that boundary the compare value is rescaled to the new period, so the duty fraction stays the same.

Top module: `pwm_edge_timer`

## Requirements
- R1: While rst_n is low, and after its release, the counter, period limit, compare registers and flags are zero: pwm_out, cycle_pulse and drop_flag are low during reset.
- R2: The counter runs 0,1,…,limit then returns to 0, so a cycle lasts limit+1 clocks. cycle_pulse is high for exactly the first clock of each cycle (counter at 0). With limit 0 it is high on every clock after reset.
- R3: pwm_out is high while counter < active compare. Each cycle therefore holds min(compare, limit+1) high clocks: compare 0 gives none and compare ≥ limit+1 gives the whole cycle.
- R4: A compare write (wr_sel=1) updates only the buffer. The active compare takes the buffer value at the next cycle boundary, either a natural wrap or a forced end.
- R5: Only the first compare write in a cycle is accepted. A later one in the same cycle leaves the buffer unchanged and sets drop_flag. drop_flag stays set until a stat_rd pulse clears it, and a new drop in the same clock wins over the clear.
- R6: A counter write (wr_sel=2, any data) ends the cycle. The counter restarts at 0, cycle_pulse follows, the buffer moves to the active compare and compare writes are open again. wr_sel=3 has no effect.
- R7: A period write (wr_sel=0, value = clocks-1) does not shorten the running cycle. It takes effect at the next boundary, and the last value written before that boundary wins.
- R8: When a new period takes effect, the compare value is replaced by floor(compare·(new+1)/(old+1)), saturated to 16 bits.
- R9: A compare write in the same clock as a boundary counts as the first write of the new cycle. It is accepted without a drop and lands in the buffer. The active compare for the new cycle is the value buffered before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one clock per write |
| wr_sel | input | 2 | Target: 0 period, 1 compare, 2 counter, 3 none |
| wr_data | input | 16 | Write value |
| stat_rd | input | 1 | Status read strobe, clears drop_flag |
| pwm_out | output | 1 | High-true PWM output |
| cycle_pulse | output | 1 | High on the first clock of each cycle |
| drop_flag | output | 1 | Sticky flag for a rejected compare write |

## Verification
A compare write can fall in the same clock as a cycle boundary, and the two outcomes pull in opposite directions. The write-once gate must reopen for the new cycle, while the active compare must still take the value buffered earlier. The bench syncs to cycle_pulse, makes an accepted compare write early in a 20-clock cycle, and counts clocks so that a second compare write lands exactly on the wrap edge. It then checks that drop_flag stays low and that the next two cycles show the old and then the new high time. The period change and a natural wrap are also made to coincide: a deferred period is measured by its unchanged length and then by the rescaled duty of the following cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PWM_W  = 16;
  localparam int PROD_W = 2 * PWM_W + 1;

  typedef enum logic [1:0] {
    SEL_PERIOD  = 2'd0,
    SEL_COMPARE = 2'd1,
    SEL_COUNTER = 2'd2,
    SEL_NONE    = 2'd3
  } wr_sel_e;

  // Keep duty fraction across a period change: c*(new+1)/(old+1), saturated.
  function automatic logic [PWM_W-1:0] pwm_rescale(
    input logic [PWM_W-1:0] c,
    input logic [PWM_W-1:0] old_lim,
    input logic [PWM_W-1:0] new_lim
  );
    logic [PWM_W:0]    np1;
    logic [PWM_W:0]    op1;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quo;
    np1  = {1'b0, new_lim} + {{PWM_W{1'b0}}, 1'b1};
    op1  = {1'b0, old_lim} + {{PWM_W{1'b0}}, 1'b1};
    prod = PROD_W'(c) * PROD_W'(np1);
    quo  = prod / PROD_W'(op1);
    if (quo > PROD_W'({PWM_W{1'b1}}))
      return {PWM_W{1'b1}};
    return quo[PWM_W-1:0];
  endfunction
endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int W = pwm_pkg::PWM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_lim,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt,
  output logic [W-1:0] lim_act,
  output logic [W-1:0] lim_next,
  output logic         lim_apply,
  output logic         boundary
);
  logic [W-1:0] lim_pend;
  logic         pend_q;

  assign boundary  = wr_cnt | (cnt == lim_act);
  assign lim_apply = boundary & pend_q;
  assign lim_next  = lim_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      lim_act  <= '0;
      lim_pend <= '0;
      pend_q   <= 1'b0;
    end else begin
      cnt <= boundary ? '0 : cnt + {{(W-1){1'b0}}, 1'b1};
      if (lim_apply)
        lim_act <= lim_pend;
      if (wr_lim) begin
        lim_pend <= wr_data;
        pend_q   <= 1'b1;
      end else if (boundary) begin
        pend_q <= 1'b0;
      end
    end
  end

  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim_act);
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (cnt == '0));
  p_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt == '0));
  p_lim_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(lim_act));
endmodule

// File: rtl/pwm_compare_buf.sv
module pwm_compare_buf #(
  parameter int W = pwm_pkg::PWM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_cmp,
  input  logic [W-1:0] wr_data,
  input  logic         boundary,
  input  logic         lim_apply,
  input  logic [W-1:0] lim_old,
  input  logic [W-1:0] lim_new,
  input  logic         stat_rd,
  output logic [W-1:0] cmp_act,
  output logic         drop_flag
);
  import pwm_pkg::*;

  logic [W-1:0] cmp_buf;
  logic         taken_q;
  logic         accept;
  logic         reject;
  logic [W-1:0] scaled;

  assign accept = wr_cmp & (~taken_q | boundary);
  assign reject = wr_cmp & ~accept;
  assign scaled = lim_apply ? pwm_rescale(cmp_buf, lim_old, lim_new) : cmp_buf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_buf   <= '0;
      cmp_act   <= '0;
      taken_q   <= 1'b0;
      drop_flag <= 1'b0;
    end else begin
      if (boundary) begin
        cmp_act <= scaled;
        cmp_buf <= accept ? wr_data : scaled;
        taken_q <= accept;
      end else if (accept) begin
        cmp_buf <= wr_data;
        taken_q <= 1'b1;
      end
      if (reject)
        drop_flag <= 1'b1;
      else if (stat_rd)
        drop_flag <= 1'b0;
    end
  end

  p_act_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(cmp_act));
  p_second_lost_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_q && wr_cmp && !boundary) |=> ($stable(cmp_buf) && drop_flag));
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_flag && !stat_rd) |=> drop_flag);
  p_edge_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && wr_cmp && !lim_apply) |=> ((cmp_act == $past(cmp_buf)) && taken_q));
endmodule

// File: rtl/pwm_edge_timer.sv
module pwm_edge_timer #(
  parameter int W = pwm_pkg::PWM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         stat_rd,
  output logic         pwm_out,
  output logic         cycle_pulse,
  output logic         drop_flag
);
  import pwm_pkg::*;

  logic         wr_lim, wr_cmp, wr_cnt;
  logic [W-1:0] cnt, lim_act, lim_next, cmp_act;
  logic         lim_apply, boundary;

  assign wr_lim = wr_en && (wr_sel == SEL_PERIOD);
  assign wr_cmp = wr_en && (wr_sel == SEL_COMPARE);
  assign wr_cnt = wr_en && (wr_sel == SEL_COUNTER);

  pwm_period_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_lim(wr_lim), .wr_cnt(wr_cnt),
    .wr_data(wr_data), .cnt(cnt), .lim_act(lim_act), .lim_next(lim_next),
    .lim_apply(lim_apply), .boundary(boundary)
  );

  pwm_compare_buf #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr_cmp(wr_cmp), .wr_data(wr_data),
    .boundary(boundary), .lim_apply(lim_apply), .lim_old(lim_act),
    .lim_new(lim_next), .stat_rd(stat_rd), .cmp_act(cmp_act),
    .drop_flag(drop_flag)
  );

  assign pwm_out = (cnt < cmp_act);

  always_ff @(posedge clk) begin
    if (!rst_n) cycle_pulse <= 1'b0;
    else        cycle_pulse <= boundary;
  end

  p_pulse_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_pulse |-> (cnt == '0));
  p_full_duty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act > lim_act) |-> pwm_out);
  p_zero_duty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act == '0) |-> !pwm_out);
  p_reset_low_r1: assert property (@(posedge clk)
    !rst_n |=> (!pwm_out && !cycle_pulse && !drop_flag));
endmodule

// File: tb/pwm_edge_timer_tb.sv
module pwm_edge_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = '0;
  logic        stat_rd = 1'b0;
  logic        pwm_out, cycle_pulse, drop_flag;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  pwm_edge_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .stat_rd(stat_rd), .pwm_out(pwm_out),
    .cycle_pulse(cycle_pulse), .drop_flag(drop_flag)
  );

  always #10 clk = ~clk;

  // {period in clocks, compare value}
  localparam logic [31:0] VEC [8] = '{
    {16'd10, 16'd3}, {16'd10, 16'd0}, {16'd10, 16'd10}, {16'd10, 16'd15},
    {16'd1, 16'd1},  {16'd1, 16'd0},  {16'd300, 16'd150}, {16'd5, 16'd4}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Called at a falling edge; returns at the falling edge after the write.
  task automatic do_wr(input logic [1:0] sel, input logic [15:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_high(input int len, output int hi);
    hi = 0;
    for (int i = 0; i < len; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
    end
  end

  initial begin
    int hi, per, cmp, exp, n;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check(pwm_out == 1'b0, "R1 pwm_out", pwm_out, 0);
    check(cycle_pulse == 1'b0, "R1 cycle_pulse", cycle_pulse, 0);
    check(drop_flag == 1'b0, "R1 drop_flag", drop_flag, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 limit 0: every clock starts a cycle
    check(cycle_pulse == 1'b1, "R2 pulse at limit 0", cycle_pulse, 1);

    // R3 table walk: period, force, compare, force, measure one cycle
    for (int v = 0; v < 8; v++) begin
      per = int'(VEC[v][31:16]);
      cmp = int'(VEC[v][15:0]);
      exp = (cmp < per) ? cmp : per;
      do_wr(2'd0, 16'(per - 1));
      do_wr(2'd2, 16'd0);
      do_wr(2'd1, 16'(cmp));
      do_wr(2'd2, 16'd0);
      count_high(per, hi);
      check(hi == exp, "R3 high clocks per cycle", hi, exp);
    end

    // R5 second compare write in a cycle is dropped and sticky
    do_wr(2'd0, 16'd99);
    do_wr(2'd2, 16'd0);
    do_wr(2'd1, 16'd20);
    do_wr(2'd1, 16'd50);
    check(drop_flag == 1'b1, "R5 drop flagged", drop_flag, 1);
    do_wr(2'd2, 16'd0);
    check(cycle_pulse == 1'b1, "R6 pulse after forced end", cycle_pulse, 1);
    count_high(100, hi);
    check(hi == 20, "R5 first write kept R4", hi, 20);
    check(drop_flag == 1'b1, "R5 flag sticky", drop_flag, 1);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    check(drop_flag == 1'b0, "R5 cleared by read", drop_flag, 0);

    // R6 forced end reopens compare writes
    do_wr(2'd1, 16'd60);
    do_wr(2'd2, 16'd0);
    do_wr(2'd1, 16'd50);
    check(drop_flag == 1'b0, "R6 write reopened", drop_flag, 0);
    do_wr(2'd2, 16'd0);
    count_high(100, hi);
    check(hi == 50, "R6 reopened value active", hi, 50);

    // R7 deferred period, R8 rescale 50*20/100 = 10
    do_wr(2'd0, 16'd19);
    n = 0;
    while (!cycle_pulse && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check(n == 99, "R7 running cycle not shortened", n, 99);
    count_high(20, hi);
    check(hi == 10, "R8 rescaled compare", hi, 10);

    // R9 compare write on the wrap edge
    do_wr(2'd1, 16'd4);
    repeat (18) @(negedge clk);
    do_wr(2'd1, 16'd16);
    check(drop_flag == 1'b0, "R9 edge write not dropped", drop_flag, 0);
    count_high(20, hi);
    check(hi == 4, "R9 old buffer active", hi, 4);
    count_high(20, hi);
    check(hi == 16, "R9 edge write lands next", hi, 16);

    // R6 select 3 does nothing
    do_wr(2'd3, 16'd0);
    check(cycle_pulse == 1'b0, "R6 select 3 ignored", cycle_pulse, 0);

    done = 1'b1;
    summary();
  end
endmodule